// File: doc/BRIEF.md
# DMA Transfer Counter with Reload

This block holds the byte count for a transfer controller's direct-memory transfers. Software writes the low and middle count bytes into write-side shadow registers. The live counter that software reads back does not change on those writes. It takes the shadow value only when a command arrives with its DMA flag set. A transfer command with the DMA flag computes the length of the next burst from three inputs: the count (where zero stands for 65536), the pending data size, and whether a command phase is pending. The length is loaded into a remaining-bytes register.

The memory side is a byte-accept handshake. Each accepted byte moves the live counter, the remaining length and the signed data size down by one step. The data size moves toward zero, and it stays fixed during a command-phase burst. When the last byte is accepted, the block does four things: it raises a one-cycle completion pulse, sets a sticky terminal-count flag, clears the live count and drops busy.

Top module: `dma_xfer_counter`

## Requirements
- R1: After reset the live count, remaining length, data size, busy, terminal-count flag and completion pulse are all zero.
- R2: A write to address 0 (low byte) or address 1 (middle byte) updates only the shadow. The live count stays as it was, and a command with bit 7 clear also leaves it unchanged.
- R3: A command with bit 7 set, issued while idle, copies the shadow count into the live count on the next clock edge.
- R4: A write to address 0 or 1 clears the terminal-count flag. A write to any other address leaves the flag unchanged.
- R5: A transfer command (bits 6:0 = 0x10, bit 7 set), issued while idle and outside a command phase, loads the remaining length with min(count, |data size|). A count of zero counts as 65536. The command also sets busy when that length is nonzero and clears the terminal-count flag. A transfer command with bit 7 clear starts nothing.
- R6: With the command-phase input high at the start, the length is min(count, 32), and the data size does not change during that burst.
- R7: Each accepted byte while busy decrements the remaining length and the live count by one and moves the data size one step toward zero. An accept while idle changes nothing.
- R8: The accept of the last byte produces a one-cycle completion pulse. On that same edge the terminal-count flag sets, the live count becomes 0 and busy falls.
- R9: A transfer command that computes a zero length leaves the block idle with no completion pulse and the terminal-count flag clear.
- R10: A count-byte write in the same cycle as the last byte accept still ends with the terminal-count flag set. The shadow takes the written byte.
- R11: While busy, data-size loads and commands are ignored.
- R12: The direction output is 1 (toward the device) when the data size is negative and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 low byte, 1 middle byte) |
| reg_wdata | input | 8 | Register write data |
| cmd_wr | input | 1 | Command strobe |
| cmd_code | input | 8 | Command byte; bit 7 DMA flag, bits 6:0 opcode |
| cmd_phase | input | 1 | A command-phase transfer is pending |
| size_wr | input | 1 | Load the pending data size |
| size_wdata | input | SIZE_W | Signed data size to load |
| byte_acc | input | 1 | Memory side accepted one byte |
| xfer_busy | output | 1 | Transfer in progress |
| to_device | output | 1 | Data size is negative |
| live_count | output | 16 | Readable live counter |
| xfer_left | output | 17 | Bytes remaining in the burst |
| data_size | output | SIZE_W | Signed remaining phase data size |
| tc_flag | output | 1 | Terminal-count status |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same clock edge: the last byte accept, which sets terminal count, and a software write of a count byte, which clears it. The bench provokes this by driving an address-0 write in the same cycle as the final accept. It then judges the outcome from two results: the flag must read set, and a later reload command must show the new byte in the live count. The other collisions are commands or size loads that arrive while a burst is running. For those, the bench expects the remaining length and the data size to stay untouched.

// File: rtl/dxc_pkg.sv
// Shared widths and command encodings for the transfer counter.
// Assumes the count is two bytes wide and the burst length one bit wider.
package dxc_pkg;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int LEN_W   = CNT_W + 1;
    localparam int DMA_BIT = 7;
    localparam logic [6:0] OP_XFER = 7'h10;
endpackage

// File: rtl/dxc_shadow.sv
// Write-side shadow for the two count bytes.
// Assumes a byte-wide write port; any address other than LO_ADDR/MID_ADDR misses.
module dxc_shadow
    import dxc_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int LO_ADDR  = 0,
    parameter int MID_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [CNT_W-1:0]  shadow,
    output logic              cnt_hit
);
    logic lo_hit, mid_hit;
    logic [BYTE_W-1:0] sh_lo, sh_mid;

    // Decode which count byte, if any, is being written.
    always_comb begin
        lo_hit  = reg_wr && (reg_addr == ADDR_W'(LO_ADDR));
        mid_hit = reg_wr && (reg_addr == ADDR_W'(MID_ADDR));
        cnt_hit = lo_hit || mid_hit;
        shadow  = {sh_mid, sh_lo};
    end

    // Capture written count bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_lo  <= '0;
            sh_mid <= '0;
        end else begin
            if (lo_hit)  sh_lo  <= reg_wdata;
            if (mid_hit) sh_mid <= reg_wdata;
        end
    end
endmodule

// File: rtl/dxc_clamp.sv
// Burst length: a zero count stands for 2**CNT_W. The result is clamped to CMD_CAP
// in command phase, or to the data-size magnitude otherwise.
// Assumes SIZE_W > LEN_W so both operands compare in SIZE_W bits.
module dxc_clamp
    import dxc_pkg::*;
#(
    parameter int SIZE_W  = 18,
    parameter int CMD_CAP = 32
) (
    input  logic                     [CNT_W-1:0] count,
    input  logic                                 cmd_phase,
    input  logic signed [SIZE_W-1:0]             size,
    output logic                     [LEN_W-1:0] len
);
    logic [SIZE_W-1:0] eff, mag, lim;

    // Widen the count, compute the limit and take the minimum.
    always_comb begin
        if (count == '0) eff = SIZE_W'(1) << CNT_W;
        else             eff = SIZE_W'(count);
        mag = size[SIZE_W-1] ? SIZE_W'(-size) : SIZE_W'(size);
        lim = cmd_phase ? SIZE_W'(CMD_CAP) : mag;
        len = (eff < lim) ? LEN_W'(eff) : LEN_W'(lim);
    end
endmodule

// File: rtl/dxc_engine.sv
// Live counter, remaining length, signed data size and terminal-count state.
// Assumes commands and size loads are only honoured while idle; when a final byte
// and a count write coincide, completion wins for the terminal-count flag.
module dxc_engine
    import dxc_pkg::*;
#(
    parameter int SIZE_W = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cnt_hit,
    input  logic [CNT_W-1:0]          shadow,
    input  logic                      cmd_wr,
    input  logic                      cmd_dma,
    input  logic                      cmd_xfer,
    input  logic                      cmd_phase,
    input  logic                      size_wr,
    input  logic signed [SIZE_W-1:0]  size_wdata,
    input  logic                      byte_acc,
    input  logic [LEN_W-1:0]          len_in,
    output logic [CNT_W-1:0]          live_count,
    output logic [LEN_W-1:0]          xfer_left,
    output logic signed [SIZE_W-1:0]  data_size,
    output logic                      busy,
    output logic                      tc_flag,
    output logic                      done_pulse
);
    logic phase_lat;
    logic last_byte;

    // Final byte of the current burst is being accepted.
    always_comb last_byte = busy && byte_acc && (xfer_left == LEN_W'(1));

    // Sequence reload, start, count-down and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_count <= '0;
            xfer_left  <= '0;
            data_size  <= '0;
            busy       <= 1'b0;
            tc_flag    <= 1'b0;
            done_pulse <= 1'b0;
            phase_lat  <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (busy) begin
                if (cnt_hit && !last_byte) tc_flag <= 1'b0;
                if (byte_acc) begin
                    xfer_left  <= xfer_left - LEN_W'(1);
                    live_count <= live_count - CNT_W'(1);
                    if (!phase_lat && data_size != '0) begin
                        if (data_size[SIZE_W-1]) data_size <= data_size + SIZE_W'(1);
                        else                     data_size <= data_size - SIZE_W'(1);
                    end
                end
                if (last_byte) begin
                    busy       <= 1'b0;
                    done_pulse <= 1'b1;
                    tc_flag    <= 1'b1;
                    live_count <= '0;
                end
            end else begin
                if (cnt_hit) tc_flag <= 1'b0;
                if (size_wr) data_size <= size_wdata;
                if (cmd_wr && cmd_dma) begin
                    live_count <= shadow;
                    if (cmd_xfer) begin
                        xfer_left <= len_in;
                        busy      <= (len_in != '0);
                        phase_lat <= cmd_phase;
                        tc_flag   <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dma_xfer_counter.sv
// Top of the transfer counter: shadow bytes, length clamp and count engine.
// Assumes the memory side signals one byte per cycle through byte_acc.
module dma_xfer_counter
    import dxc_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int SIZE_W  = 18,
    parameter int CMD_CAP = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [7:0]               reg_wdata,
    input  logic                     cmd_wr,
    input  logic [7:0]               cmd_code,
    input  logic                     cmd_phase,
    input  logic                     size_wr,
    input  logic [SIZE_W-1:0]        size_wdata,
    input  logic                     byte_acc,
    output logic                     xfer_busy,
    output logic                     to_device,
    output logic [15:0]              live_count,
    output logic [16:0]              xfer_left,
    output logic [SIZE_W-1:0]        data_size,
    output logic                     tc_flag,
    output logic                     done_pulse
);
    logic [CNT_W-1:0] shadow, cnt_src;
    logic             cnt_hit, cmd_dma, cmd_xfer;
    logic [LEN_W-1:0] len;
    logic signed [SIZE_W-1:0] size_s;

    // Split the command byte and pick the count the clamp sees.
    always_comb begin
        cmd_dma   = cmd_code[DMA_BIT];
        cmd_xfer  = (cmd_code[6:0] == OP_XFER);
        cnt_src   = cmd_dma ? shadow : live_count;
        to_device = size_s[SIZE_W-1];
        data_size = size_s;
    end

    dxc_shadow #(.ADDR_W(ADDR_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .shadow(shadow), .cnt_hit(cnt_hit)
    );

    dxc_clamp #(.SIZE_W(SIZE_W), .CMD_CAP(CMD_CAP)) u_clamp (
        .count(cnt_src), .cmd_phase(cmd_phase), .size(size_s), .len(len)
    );

    dxc_engine #(.SIZE_W(SIZE_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .cnt_hit(cnt_hit), .shadow(shadow),
        .cmd_wr(cmd_wr), .cmd_dma(cmd_dma), .cmd_xfer(cmd_xfer),
        .cmd_phase(cmd_phase), .size_wr(size_wr), .size_wdata(size_wdata),
        .byte_acc(byte_acc), .len_in(len), .live_count(live_count),
        .xfer_left(xfer_left), .data_size(size_s), .busy(xfer_busy),
        .tc_flag(tc_flag), .done_pulse(done_pulse)
    );
endmodule

// File: rtl/dxc_checker.sv
// Temporal checks on the transfer counter's ports; attached by bind.
module dxc_checker #(
    parameter int ADDR_W = 4,
    parameter int SIZE_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              cmd_wr,
    input logic [7:0]        cmd_code,
    input logic              byte_acc,
    input logic              xfer_busy,
    input logic [15:0]       live_count,
    input logic [16:0]       xfer_left,
    input logic [SIZE_W-1:0] data_size,
    input logic              tc_flag,
    input logic              done_pulse
);
    // R8
    done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (tc_flag && !xfer_busy && live_count == 16'd0));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    // R7
    left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && byte_acc && xfer_left > 17'd1) |=> (xfer_left == $past(xfer_left) - 17'd1));
    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |-> (xfer_left != 17'd0));
    // R11
    size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !byte_acc) |=> $stable(data_size));
    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_busy && !(cmd_wr && cmd_code[7])) |=> $stable(live_count));
    // R4
    tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr <= ADDR_W'(1) && !(xfer_busy && byte_acc && xfer_left == 17'd1))
        |=> !tc_flag);
endmodule

bind dma_xfer_counter dxc_checker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .cmd_wr(cmd_wr), .cmd_code(cmd_code), .byte_acc(byte_acc),
    .xfer_busy(xfer_busy), .live_count(live_count), .xfer_left(xfer_left),
    .data_size(data_size), .tc_flag(tc_flag), .done_pulse(done_pulse)
);

// File: tb/dma_xfer_counter_tb.sv
// Directed bench: one task per scenario; inputs change 1 time unit after a rising edge.
module dma_xfer_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 18;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, cmd_wr = 1'b0, cmd_phase = 1'b0, size_wr = 1'b0, byte_acc = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, cmd_code = '0;
    logic [SW-1:0] size_wdata = '0;
    logic xfer_busy, to_device, tc_flag, done_pulse;
    logic [15:0] live_count;
    logic [16:0] xfer_left;
    logic [SW-1:0] data_size;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xfer_counter u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .cmd_phase(cmd_phase), .size_wr(size_wr), .size_wdata(size_wdata),
        .byte_acc(byte_acc), .xfer_busy(xfer_busy), .to_device(to_device),
        .live_count(live_count), .xfer_left(xfer_left), .data_size(data_size),
        .tc_flag(tc_flag), .done_pulse(done_pulse)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sz();
        return int'($signed(data_size));
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr_reg(input int a, input int d);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
        tick(); reg_wr = 1'b0;
    endtask

    task automatic set_count(input int c);
        wr_reg(0, c & 255); wr_reg(1, (c >> 8) & 255);
    endtask

    task automatic issue(input int code);
        cmd_wr = 1'b1; cmd_code = 8'(code);
        tick(); cmd_wr = 1'b0;
    endtask

    task automatic load_size(input int v);
        size_wr = 1'b1; size_wdata = SW'(v);
        tick(); size_wr = 1'b0;
    endtask

    task automatic accept(input int n);
        byte_acc = 1'b1;
        repeat (n) @(posedge clk);
        #1; byte_acc = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "live", int'(live_count), 0);
        chk("R1", "left", int'(xfer_left), 0);
        chk("R1", "size", sz(), 0);
        chk("R1", "busy", int'(xfer_busy), 0);
        chk("R1", "tc", int'(tc_flag), 0);
        chk("R1", "done", int'(done_pulse), 0);
    endtask

    task automatic t_shadow();
        set_count(16'h1234);
        chk("R2", "live after shadow write", int'(live_count), 0);
        issue(8'h00);
        chk("R2", "live after non-DMA cmd", int'(live_count), 0);
        issue(8'h80);
        chk("R3", "live after reload", int'(live_count), 16'h1234);
    endtask

    task automatic t_data_in();
        load_size(5); set_count(3); issue(8'h90);
        chk("R5", "left", int'(xfer_left), 3);
        chk("R5", "busy", int'(xfer_busy), 1);
        chk("R12", "dir", int'(to_device), 0);
        accept(1);
        chk("R7", "left", int'(xfer_left), 2);
        chk("R7", "live", int'(live_count), 2);
        chk("R7", "size", sz(), 4);
        accept(2);
        chk("R8", "done", int'(done_pulse), 1);
        chk("R8", "tc", int'(tc_flag), 1);
        chk("R8", "live", int'(live_count), 0);
        chk("R8", "busy", int'(xfer_busy), 0);
        chk("R8", "size", sz(), 2);
        tick();
        chk("R8", "done single", int'(done_pulse), 0);
        wr_reg(3, 8'h55);
        chk("R4", "tc after other addr", int'(tc_flag), 1);
        wr_reg(1, 0);
        chk("R4", "tc after count write", int'(tc_flag), 0);
    endtask

    task automatic t_data_out();
        load_size(-4); set_count(10);
        accept(1);
        chk("R7", "idle accept left", int'(xfer_left), 0);
        chk("R7", "idle accept size", sz(), -4);
        issue(8'h90);
        chk("R5", "neg left", int'(xfer_left), 4);
        chk("R12", "dir", int'(to_device), 1);
        accept(4);
        chk("R7", "size toward zero", sz(), 0);
        chk("R8", "done", int'(done_pulse), 1);
    endtask

    task automatic t_cmd_phase();
        load_size(50); set_count(100);
        cmd_phase = 1'b1; issue(8'h90); cmd_phase = 1'b0;
        chk("R6", "left capped", int'(xfer_left), 32);
        accept(32);
        chk("R6", "size held", sz(), 50);
        chk("R6", "done", int'(done_pulse), 1);
    endtask

    task automatic t_zero_len();
        load_size(0); set_count(5); issue(8'h90);
        chk("R9", "busy", int'(xfer_busy), 0);
        chk("R9", "tc cleared", int'(tc_flag), 0);
        tick();
        chk("R9", "done", int'(done_pulse), 0);
        load_size(5); issue(8'h10);
        chk("R5", "no DMA xfer busy", int'(xfer_busy), 0);
        chk("R5", "no DMA xfer left", int'(xfer_left), 0);
    endtask

    task automatic t_busy_ignore();
        load_size(10); set_count(6); issue(8'h90);
        load_size(99);
        chk("R11", "size while busy", sz(), 10);
        set_count(2); issue(8'h90);
        chk("R11", "left while busy", int'(xfer_left), 6);
        accept(6);
        chk("R11", "size after", sz(), 4);
        chk("R8", "done", int'(done_pulse), 1);
    endtask

    task automatic t_collide();
        load_size(3); set_count(2); issue(8'h90);
        accept(1);
        chk("R7", "left", int'(xfer_left), 1);
        byte_acc = 1'b1; reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 8'h77;
        tick();
        byte_acc = 1'b0; reg_wr = 1'b0;
        chk("R10", "tc", int'(tc_flag), 1);
        chk("R10", "done", int'(done_pulse), 1);
        issue(8'h80);
        chk("R10", "shadow took byte", int'(live_count), 16'h0077);
    endtask

    task automatic t_full();
        load_size(70000); set_count(0); issue(8'h90);
        chk("R5", "zero means 65536", int'(xfer_left), 65536);
        accept(65536);
        chk("R8", "full done", int'(done_pulse), 1);
        chk("R7", "full size", sz(), 70000 - 65536);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        t_reset();
        t_shadow();
        t_data_in();
        t_data_out();
        t_cmd_phase();
        t_zero_len();
        t_busy_ignore();
        t_collide();
        t_full();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule